// File: doc/BRIEF.md
# Display Transmitter Control Target on I2C

This block is a bit-level I2C target for the control port of a display transmitter. The inputs SCL and SDA are synchronised to a fast system clock. The block drives SDA only by pulling it low through an output enable. Its 7-bit bus address is a parameter. After a write-direction address, the first data byte selects a register. The bytes that follow are written to, or read from, that register, and the register pointer steps forward after each byte.

Most registers are read-only constants: an identity value, an interrupt status that always shows a sink present, and zero everywhere else. The one register with an effect is the system-control register. Its request and grant bits form a handshake that moves the transmitter into a pass-through mode for the display data channel and back out of it. That mode is brought out on a status pin, so that the surrounding logic can route the display data channel.

Top module: `disp_ctl_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the parameter DEV_ADDR (default 0x39, bit 0 = 1 for read). Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: The first data byte after a matching write-direction address loads the register pointer and is written into no register.
- R3: The pointer increments by one (modulo 256) after each data byte written or read, so that bursts walk through consecutive registers.
- R4: Register 0x1B always reads 0xB0.
- R5: Register 0x3D always reads 0x04 (sink present, hot-plug event bit 0x01 clear).
- R6: A write to register 0x1A with bit 2 set sets the request flag. If bit 1 is also set, the write enters pass-through mode (ddc_mode_o = 1). If bit 1 is clear, the mode is left as it was.
- R7: A write to register 0x1A with bit 2 clear clears the request flag and leaves pass-through mode.
- R8: Register 0x1A reads 0x06 while the request flag is set, and 0x00 otherwise.
- R9: All other registers read 0x00. Writes to any register other than 0x1A are acknowledged and change nothing that can be read.
- R10: Reset clears the pointer, the request flag, pass-through mode and the pointer-expected flag, and releases SDA.
- R11: Read data leaves the target most significant bit first. A master NACK ends the burst, and SDA is released so that a STOP completes.
- R12: A repeated START with read direction keeps the current pointer.
- R13: Every data byte written to a matching target is acknowledged, and SDA only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pulls SDA low |
| ddc_mode_o | output | 1 | Pass-through mode for the display data channel is active |

## Verification
The bench attacks the three-way handshake on the control register. A write with only the request bit must leave the mode unchanged, and a design that treated the grant bit as a level would drop out of the mode. Pointer handling is probed next. Two pointer-only transactions aimed at the control register must not disturb the mode, which would be cleared if the pointer byte leaked into a register. A burst across 0x1A through 0x1C, and a write burst that ends on 0x1A, expose a pointer that skips or fails to step. Writes to the constant registers, a foreign address, a NACK-terminated read followed by a STOP, and a reset taken while in the mode catch a target that corrupts constants, answers the wrong address, holds SDA after the burst, or keeps stale state.

// File: rtl/dtx_i2c_pkg.sv
package dtx_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] REG_SYSCTL = 8'h1A;
    localparam logic [BYTE_W-1:0] REG_IDENT  = 8'h1B;
    localparam logic [BYTE_W-1:0] REG_IRQST  = 8'h3D;

    localparam int BIT_REQ = 2;
    localparam int BIT_GNT = 1;

    localparam logic [BYTE_W-1:0] VAL_IDENT  = 8'hB0;
    localparam logic [BYTE_W-1:0] VAL_IRQST  = 8'h04;
    localparam logic [BYTE_W-1:0] VAL_GRANT  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
    } eng_st_e;
endpackage

// File: rtl/dtx_line_sync.sv
module dtx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_p    = q.scl_pipe[STAGES-1];
        d.sda_p    = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s && !q.scl_p;
    assign scl_fall  = !scl_s && q.scl_p;
    assign start_det = scl_s && q.scl_p && q.sda_p && !sda_s;
    assign stop_det  = scl_s && q.scl_p && !q.sda_p && sda_s;
endmodule

// File: rtl/dtx_i2c_engine.sv
module dtx_i2c_engine
    import dtx_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ptr_arm,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              done;
        logic              rw;
        logic              nack;
        logic              oe;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d       = q;
        ptr_arm = 1'b0;
        wr_stb  = 1'b0;
        rd_stb  = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.done = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WBYTE: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt  = q.cnt + 1'b1;
                        d.done = (q.cnt == LAST_BIT);
                    end else if (scl_fall && q.done) begin
                        d.done = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                d.st    = ST_AACK;
                                d.oe    = 1'b1;
                                d.rw    = q.sh[0];
                                ptr_arm = !q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st   = ST_WACK;
                            d.oe   = 1'b1;
                            wr_stb = 1'b1;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.st == ST_AACK && q.rw) begin
                            d.st = ST_RBYTE;
                            d.sh = rd_data;
                            d.oe = !rd_data[BYTE_W-1];
                        end else begin
                            d.st = ST_WBYTE;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st   = ST_RACK;
                            d.oe   = 1'b0;
                            d.nack = 1'b0;
                            rd_stb = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = !q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_RBYTE;
                            d.sh  = rd_data;
                            d.oe  = !rd_data[BYTE_W-1];
                            d.cnt = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign wr_data = q.sh;
    assign sda_oe  = q.oe;
endmodule

// File: rtl/dtx_ctl_regs.sv
module dtx_ctl_regs
    import dtx_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_arm,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              req_o,
    output logic              ddc_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] ptr;
        logic              arm;
        logic              req;
        logic              ddc;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (ptr_arm) begin
            d.arm = 1'b1;
        end else if (wr_stb) begin
            if (q.arm) begin
                d.ptr = wr_data;
                d.arm = 1'b0;
            end else begin
                if (q.ptr == REG_SYSCTL) begin
                    if (wr_data[BIT_REQ]) begin
                        d.req = 1'b1;
                        if (wr_data[BIT_GNT]) d.ddc = 1'b1;
                    end else begin
                        d.req = 1'b0;
                        d.ddc = 1'b0;
                    end
                end
                d.ptr = q.ptr + 1'b1;
            end
        end else if (rd_stb) begin
            d.ptr = q.ptr + 1'b1;
        end
    end

    always_comb begin
        case (q.ptr)
            REG_SYSCTL: rd_data = q.req ? VAL_GRANT : '0;
            REG_IDENT:  rd_data = VAL_IDENT;
            REG_IRQST:  rd_data = VAL_IRQST;
            default:    rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr_o = q.ptr;
    assign req_o = q.req;
    assign ddc_o = q.ddc;
endmodule

// File: rtl/disp_ctl_i2c_target.sv
module disp_ctl_i2c_target
    import dtx_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h39,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic ddc_mode_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ptr_arm, wr_stb, rd_stb, req_q;
    logic [BYTE_W-1:0] wr_data, rd_data, ptr_q;

    dtx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dtx_i2c_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr_arm(ptr_arm), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    dtx_ctl_regs regs_i (
        .clk(clk), .rst_n(rst_n), .ptr_arm(ptr_arm), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data),
        .ptr_o(ptr_q), .req_o(req_q), .ddc_o(ddc_mode_o)
    );
endmodule

// File: rtl/dtx_i2c_checker.sv
module dtx_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       ddc_mode_o,
    input logic       ptr_arm,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic [7:0] ptr_q,
    input logic       req_q
);
    assert_oe_rise_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_mode_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ddc_mode_o |-> req_q);

    assert_mode_enter_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ddc_mode_o) |-> $past(wr_stb));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_arm, wr_stb, rd_stb}));

    assert_read_steps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> ptr_q == $past(ptr_q) + 8'd1);

    assert_mode_leave_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ddc_mode_o) |-> $past(wr_stb));
endmodule

bind disp_ctl_i2c_target dtx_i2c_checker chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .ddc_mode_o(ddc_mode_o), .ptr_arm(ptr_arm), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .ptr_q(ptr_q), .req_q(req_q)
);

// File: tb/disp_ctl_i2c_target_tb_top.sv
`timescale 1ns/1ps
module disp_ctl_i2c_target_tb_top;
    localparam int Q = 10;
    localparam logic [7:0] AW = 8'h72;
    localparam logic [7:0] AR = 8'h73;

    logic clk = 0;
    logic rst_n = 0;
    logic m_scl = 1, m_sda = 1;
    logic sda_oe, ddc_mode_o;
    wire  sda_line = m_sda & ~sda_oe;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    always #5 clk = ~clk;

    disp_ctl_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ddc_mode_o(ddc_mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    always begin
        @(negedge clk);
        if (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() == 0) begin
                chk("scoreboard", a, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), a, exp_q.pop_front());
            end
        end
    end

    task automatic i2c_start();
        m_sda = 1; tick(Q);
        m_scl = 1; tick(Q);
        m_sda = 0; tick(Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 0; tick(Q);
        m_scl = 1; tick(Q);
        m_sda = 1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1; tick(2 * Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1; tick(Q);
        m_scl = 1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            v[i] = b;
        end
        send_bit(last);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic ack;
        i2c_start();
        wr_byte(AW, ack); chk("R1 own address ack", {7'd0, ack}, 8'd1);
        wr_byte(p, ack);  chk("R13 pointer byte ack", {7'd0, ack}, 8'd1);
    endtask

    task automatic write_regs(input logic [7:0] p, input logic [7:0] d0,
                              input logic [7:0] d1, input int n);
        logic ack;
        set_ptr(p);
        wr_byte(d0, ack); chk("R13 data ack", {7'd0, ack}, 8'd1);
        if (n > 1) begin
            wr_byte(d1, ack); chk("R13 data ack", {7'd0, ack}, 8'd1);
        end
        i2c_stop();
    endtask

    task automatic read_from(input logic [7:0] p, input int n);
        logic ack;
        logic [7:0] v;
        set_ptr(p);
        i2c_start();
        wr_byte(AR, ack); chk("R12 read address ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i == n - 1, v);
            act_q.push_back(v);
        end
        i2c_stop();
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        tick(3);
        chk("R10 sda released in reset", {7'd0, sda_oe}, 8'd0);
        chk("R10 mode clear in reset", {7'd0, ddc_mode_o}, 8'd0);
        rst_n = 1;
        tick(10);

        i2c_start();
        wr_byte(8'h20, ack);
        chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
        i2c_stop();
        i2c_start();
        wr_byte(8'h21, ack);
        chk("R1 foreign read nack", {7'd0, ack}, 8'd0);
        i2c_stop();

        expect_byte(8'hB0, "R4 identity R11 R12");
        read_from(8'h1B, 1);
        expect_byte(8'h04, "R5 interrupt status");
        read_from(8'h3D, 1);
        expect_byte(8'h00, "R8 control idle");
        read_from(8'h1A, 1);

        write_regs(8'h1A, 8'h06, 8'h00, 1);
        chk("R6 enter mode", {7'd0, ddc_mode_o}, 8'd1);
        expect_byte(8'h06, "R8 control granted");
        expect_byte(8'hB0, "R3 burst step");
        expect_byte(8'h00, "R3 R9 burst step");
        read_from(8'h1A, 3);

        set_ptr(8'h1A); i2c_stop();
        set_ptr(8'h1A); i2c_stop();
        chk("R2 pointer byte not written", {7'd0, ddc_mode_o}, 8'd1);

        write_regs(8'h1A, 8'h04, 8'h00, 1);
        chk("R6 request-only keeps mode", {7'd0, ddc_mode_o}, 8'd1);

        write_regs(8'h19, 8'h55, 8'h00, 2);
        chk("R7 R3 write burst leaves mode", {7'd0, ddc_mode_o}, 8'd0);
        expect_byte(8'h00, "R7 control cleared");
        read_from(8'h1A, 1);

        write_regs(8'h1A, 8'h04, 8'h00, 1);
        chk("R6 request-only no entry", {7'd0, ddc_mode_o}, 8'd0);
        expect_byte(8'h06, "R8 request flag set");
        read_from(8'h1A, 1);

        write_regs(8'h3D, 8'hFF, 8'h00, 1);
        write_regs(8'h1B, 8'h12, 8'h00, 1);
        write_regs(8'h10, 8'h77, 8'h00, 1);
        expect_byte(8'h04, "R9 status write ignored");
        read_from(8'h3D, 1);
        expect_byte(8'hB0, "R9 identity write ignored");
        read_from(8'h1B, 1);
        expect_byte(8'h00, "R9 plain register write ignored");
        read_from(8'h10, 1);

        chk("R11 sda released after nack", {7'd0, sda_oe}, 8'd0);
        chk("R11 line high after stop", {7'd0, sda_line}, 8'd1);

        write_regs(8'h1A, 8'h06, 8'h00, 1);
        chk("R6 enter mode again", {7'd0, ddc_mode_o}, 8'd1);
        rst_n = 0;
        tick(3);
        chk("R10 reset leaves mode", {7'd0, ddc_mode_o}, 8'd0);
        rst_n = 1;
        tick(5);
        expect_byte(8'h00, "R10 request flag cleared");
        read_from(8'h1A, 1);

        tick(20);
        chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule